// File: doc/BRIEF.md
# VBI Line Qualifier and Field Packer

This block sits on the video pixel clock beside a video decoder that emits ancillary data packets during the vertical blanking lines. It tracks where it is in the picture from the active-low horizontal and vertical sync inputs. Every blanking-line packet that arrives on the byte bus has a four-byte line header. The block checks each packet against three optional filters: a position window in lines and pixels, a window over the line number carried in the header, and a data-type match. Packets that pass are written into a 1 KB field buffer through a simple write port.

Once the blanking region ends, the block closes the field record. It writes a run of zero bytes as a synchronization marker, then a tagged header for the infrared receiver samples, then those samples, which it reads from an indexed sampler interface. It then raises a ready flag and hands the buffer to a readout engine. The block makes no further writes until that engine reports that it has drained the buffer. A field that would not fit is cut at the last whole line, flagged, and closed at once.

Top module: `vbi_field_packer`

## Requirements
- R1: After reset, `field_ready`, `overflow` and `buf_we` are 0 and `fill_level` is 0.
- R2: An accepted line is stored as SDID 0x85, the DC byte {2'b10, n[5:0]}, IDI1 {P, FID, L[8:3]}, IDI2 {P, L[2:0], DT[3:0]} and then n data bytes, at consecutive addresses. The first line of a field goes to address 0. A line is dropped if its DC byte does not carry 2'b10 in bits 7:6, or if IDI1 or IDI2 does not have an odd number of ones over bits 7:0.
- R3: When `qual_cfg[6]`=1, a line is kept only if the line count is at least `win_offset` and the pixel count at its SDID byte is below `line_len`. The line count is the number of rising HSYNC edges since the last rising VSYNC edge. The pixel count is the number of clock cycles since the last rising HSYNC edge.
- R4: When `qual_cfg[4]`=1, a line is kept only if its header line number L is within 2 to 21. When the window of R3 is also enabled, a line must pass both.
- R5: When `qual_cfg[7]`=1, a line is kept only if its DT nibble equals `qual_cfg[3:0]`.
- R6: Lines with DT equal to 7, 11 or 15 are dropped unless `qual_cfg[5]`=1.
- R7: A dropped line leaves no bytes in the record. The next accepted line is stored at the address where the dropped line began.
- R8: On the rising HSYNC edge that brings the line count to 22, the block writes 16 bytes of 0x00. It then writes {4'b0111, ir_len}, then ir_len bytes taken from `ir_data` while `ir_idx` counts 0, 1, and so on.
- R9: After the last sample byte, `field_ready` rises and `fill_level` gives the record length. Both hold, and nothing is written, until `drain_done` is pulsed. Sync edges and packets that arrive meanwhile are ignored.
- R10: If a write would pass address 1023, the partial line is discarded and `overflow` is set. `fill_level` then covers only the whole lines and `field_ready` rises at once. `overflow` is cleared when the next field starts.
- R11: A packet still in progress when the region ends (R8) is discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| pkt_valid | input | 1 | Packet byte strobe |
| pkt_data | input | 8 | Packet byte |
| qual_cfg | input | 8 | Filter config: 7 type en, 6 position win en, 5 raw en, 4 line-number win en, 3:0 type code |
| win_offset | input | 9 | First line of the position window |
| line_len | input | 11 | Pixel limit of the position window |
| ir_len | input | 4 | Number of IR sample bytes |
| ir_data | input | 8 | IR sample byte at index `ir_idx` |
| drain_done | input | 1 | Readout has drained the buffer |
| ir_idx | output | 4 | Index of the IR sample being read |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | 10 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| field_ready | output | 1 | Field record complete, buffer owned by readout |
| fill_level | output | 11 | Record length in bytes |
| overflow | output | 1 | Current field was cut short |

## Verification
The bench first lets rejected lines, such as ones with bad parity, a malformed count byte or a raw type, start writing. It then puts an accepted line right after them. A design that failed to rewind would leave stale header bytes and shift every later address. A packet that straddles the end of the blanking region checks that partial lines never reach the record, and a 16-line field of 67-byte lines pushes the buffer past 1024 bytes to check the cut at a line boundary and the overflow flag. A full field is also sent while the record is still unread, so a design that did not honour the ready handshake would overwrite data or change the length.

// File: rtl/vbi_pack_pkg.sv
// Shared constants, state encoding and helper functions for the VBI packer.
package vbi_pack_pkg;

    localparam logic [7:0] SDID_CODE = 8'h85;
    localparam int         DC_W      = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DC,
        ST_ID1,
        ST_ID2,
        ST_DATA,
        ST_SKIP,
        ST_WAITLN,
        ST_BURST,
        ST_IRHDR,
        ST_IRDAT,
        ST_READY
    } wr_state_e;

    // True when the byte has an odd number of ones.
    function automatic logic parity_odd(input logic [7:0] b);
        return ^b;
    endfunction

    // Type codes treated as raw or reserved.
    function automatic logic is_raw_type(input logic [3:0] dt);
        return (dt == 4'd7) || (dt == 4'd11) || (dt == 4'd15);
    endfunction

endpackage

// File: rtl/vbi_sync_tracker.sv
// Tracks picture position from active-low sync inputs.
// Assumes: syncs are synchronous to clk; a rising edge ends each sync pulse.
// pix_cnt counts cycles since the last HSYNC rise, line_cnt counts HSYNC
// rises since the last VSYNC rise. region_end pulses on the HSYNC rise that
// brings line_cnt to END_LINE.
module vbi_sync_tracker #(
    parameter int PIX_W    = 11,
    parameter int LINE_W   = 9,
    parameter int END_LINE = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_n,
    input  logic              vsync_n,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              line_start,
    output logic              field_start,
    output logic              region_end
);
    logic hs_q, hs_qq, vs_q, vs_qq;
    logic hs_rise, vs_rise;

    // Register the sync inputs twice to find their rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b1;
            hs_qq <= 1'b1;
            vs_q  <= 1'b1;
            vs_qq <= 1'b1;
        end else begin
            hs_q  <= hsync_n;
            hs_qq <= hs_q;
            vs_q  <= vsync_n;
            vs_qq <= vs_q;
        end
    end

    assign hs_rise = hs_q & ~hs_qq;
    assign vs_rise = vs_q & ~vs_qq;

    // Pixel counter: clears on each line start, saturates at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
        end else if (hs_rise) begin
            pix_cnt <= '0;
        end else if (pix_cnt != {PIX_W{1'b1}}) begin
            pix_cnt <= pix_cnt + PIX_W'(1);
        end
    end

    // Line counter: clears on field start, counts line starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (vs_rise) begin
            line_cnt <= '0;
        end else if (hs_rise && (line_cnt != {LINE_W{1'b1}})) begin
            line_cnt <= line_cnt + LINE_W'(1);
        end
    end

    assign line_start  = hs_rise;
    assign field_start = vs_rise;
    assign region_end  = hs_rise && !vs_rise && (line_cnt == LINE_W'(END_LINE - 1));

    // R3
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (line_cnt == '0));

    // R3
    pix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (pix_cnt == '0));

endmodule

// File: rtl/vbi_line_qualifier.sv
// Decides whether a captured line header passes the enabled filters.
// Assumes: hdr_id1 is the stored IDI1 byte, hdr_id2 the IDI2 byte on the bus
// now, win_ok the position-window result taken at the SDID byte.
module vbi_line_qualifier #(
    parameter int VBI_FIRST = 2,
    parameter int VBI_LAST  = 21
) (
    input  logic [7:0] qual_cfg,
    input  logic       win_ok,
    input  logic [7:0] hdr_id1,
    input  logic [7:0] hdr_id2,
    output logic       accept
);
    import vbi_pack_pkg::*;

    logic [8:0] hdr_line;
    logic [3:0] hdr_type;
    logic       par_ok, pos_ok, lnum_ok, type_ok, raw_ok;

    // Combine all filters by intersection.
    always_comb begin
        hdr_line = {hdr_id1[5:0], hdr_id2[6:4]};
        hdr_type = hdr_id2[3:0];
        par_ok   = parity_odd(hdr_id1) && parity_odd(hdr_id2);
        pos_ok   = !qual_cfg[6] || win_ok;
        lnum_ok  = !qual_cfg[4] ||
                   ((hdr_line >= 9'(VBI_FIRST)) && (hdr_line <= 9'(VBI_LAST)));
        type_ok  = !qual_cfg[7] || (hdr_type == qual_cfg[3:0]);
        raw_ok   = qual_cfg[5] || !is_raw_type(hdr_type);
        accept   = par_ok && pos_ok && lnum_ok && type_ok && raw_ok;
    end

endmodule

// File: rtl/vbi_field_writer.sv
// Writes accepted lines, the sync burst and the IR section into the buffer.
// Assumes: a line is written speculatively from its SDID byte and rewound
// to line_base if later rejected; the readout never reads while writing,
// which the ready/drain handshake guarantees.
module vbi_field_writer #(
    parameter int DEPTH     = 1024,
    parameter int BURST_LEN = 16,
    parameter int ADDR_W    = $clog2(DEPTH),
    parameter int PTR_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_start,
    input  logic              region_end,
    input  logic              win_ok,
    input  logic              accept,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_data,
    input  logic [3:0]        ir_len,
    input  logic [7:0]        ir_data,
    input  logic              drain_done,
    output logic [3:0]        ir_idx,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata,
    output logic              field_ready,
    output logic [PTR_W-1:0]  fill_level,
    output logic              overflow,
    output logic [7:0]        hdr_id1,
    output logic              hdr_win
);
    import vbi_pack_pkg::*;

    wr_state_e       state;
    logic [PTR_W-1:0] wr_ptr, line_base;
    logic [DC_W-1:0]  cnt;
    logic [3:0]       ir_cnt, ir_len_q;
    logic             want, room, ovf_hit, in_pkt;

    // Decide whether the current cycle wants a buffer write and with what.
    always_comb begin
        in_pkt = (state == ST_HUNT) || (state == ST_DC) || (state == ST_ID1) ||
                 (state == ST_ID2)  || (state == ST_DATA) || (state == ST_SKIP) ||
                 (state == ST_WAITLN);
        want      = 1'b0;
        buf_wdata = pkt_data;
        case (state)
            ST_HUNT:  want = pkt_valid && (pkt_data == SDID_CODE);
            ST_DC:    want = pkt_valid && (pkt_data[7:6] == 2'b10);
            ST_ID1:   want = pkt_valid;
            ST_ID2:   want = pkt_valid && accept;
            ST_DATA:  want = pkt_valid;
            ST_BURST: begin want = 1'b1; buf_wdata = 8'h00; end
            ST_IRHDR: begin want = 1'b1; buf_wdata = {4'b0111, ir_len}; end
            ST_IRDAT: begin want = 1'b1; buf_wdata = ir_data; end
            default:  want = 1'b0;
        endcase
        if (in_pkt && region_end) want = 1'b0;
        room    = (wr_ptr < PTR_W'(DEPTH));
        buf_we  = want && room;
        ovf_hit = want && !room;
    end

    assign buf_waddr   = wr_ptr[ADDR_W-1:0];
    assign field_ready = (state == ST_READY);
    assign fill_level  = wr_ptr;
    assign ir_idx      = ir_cnt;

    // Main sequencer: line capture, rewind, region close and handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wr_ptr    <= '0;
            line_base <= '0;
            cnt       <= '0;
            ir_cnt    <= '0;
            ir_len_q  <= '0;
            overflow  <= 1'b0;
            hdr_id1   <= '0;
            hdr_win   <= 1'b0;
        end else begin
            if (buf_we) wr_ptr <= wr_ptr + PTR_W'(1);
            if (ovf_hit) begin
                overflow <= 1'b1;
                state    <= ST_READY;
                if (in_pkt) wr_ptr <= line_base;
            end else if (in_pkt && region_end) begin
                wr_ptr <= line_base;
                cnt    <= DC_W'(BURST_LEN);
                state  <= ST_BURST;
            end else begin
                case (state)
                    ST_IDLE: if (field_start) begin
                        wr_ptr    <= '0;
                        line_base <= '0;
                        overflow  <= 1'b0;
                        state     <= ST_HUNT;
                    end
                    ST_HUNT: if (buf_we) begin
                        hdr_win <= win_ok;
                        state   <= ST_DC;
                    end
                    ST_DC: if (pkt_valid) begin
                        if (buf_we) begin
                            cnt   <= pkt_data[DC_W-1:0];
                            state <= ST_ID1;
                        end else begin
                            wr_ptr <= line_base;
                            state  <= ST_WAITLN;
                        end
                    end
                    ST_ID1: if (pkt_valid) begin
                        hdr_id1 <= pkt_data;
                        state   <= ST_ID2;
                    end
                    ST_ID2: if (pkt_valid) begin
                        if (accept) begin
                            if (cnt == '0) begin
                                line_base <= wr_ptr + PTR_W'(1);
                                state     <= ST_HUNT;
                            end else begin
                                state <= ST_DATA;
                            end
                        end else begin
                            wr_ptr <= line_base;
                            state  <= (cnt == '0) ? ST_HUNT : ST_SKIP;
                        end
                    end
                    ST_DATA: if (pkt_valid) begin
                        cnt <= cnt - DC_W'(1);
                        if (cnt == DC_W'(1)) begin
                            line_base <= wr_ptr + PTR_W'(1);
                            state     <= ST_HUNT;
                        end
                    end
                    ST_SKIP: if (pkt_valid) begin
                        cnt <= cnt - DC_W'(1);
                        if (cnt == DC_W'(1)) state <= ST_HUNT;
                    end
                    ST_WAITLN: if (line_start) state <= ST_HUNT;
                    ST_BURST: begin
                        cnt <= cnt - DC_W'(1);
                        if (cnt == DC_W'(1)) state <= ST_IRHDR;
                    end
                    ST_IRHDR: begin
                        ir_len_q <= ir_len;
                        ir_cnt   <= '0;
                        state    <= (ir_len == 4'd0) ? ST_READY : ST_IRDAT;
                    end
                    ST_IRDAT: begin
                        ir_cnt <= ir_cnt + 4'd1;
                        if (ir_cnt == ir_len_q - 4'd1) state <= ST_READY;
                    end
                    ST_READY: if (drain_done) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_ready && !drain_done) |=> field_ready);

    // R9
    fill_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_ready && $past(field_ready)) |-> $stable(fill_level));

    // R10
    ovf_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> field_ready);

    // R10
    ovf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (fill_level <= PTR_W'(DEPTH)));

endmodule

// File: rtl/vbi_field_packer.sv
// Top level: position tracking, line qualification and field record writing.
// Assumes: all inputs are synchronous to the video clock; the buffer SRAM
// and the serial readout sit outside and use the write port and handshake.
module vbi_field_packer #(
    parameter int DEPTH     = 1024,
    parameter int BURST_LEN = 16,
    parameter int PIX_W     = 11,
    parameter int LINE_W    = 9,
    parameter int VBI_FIRST = 2,
    parameter int VBI_LAST  = 21,
    parameter int END_LINE  = 22,
    parameter int ADDR_W    = $clog2(DEPTH),
    parameter int PTR_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_n,
    input  logic              vsync_n,
    input  logic              pkt_valid,
    input  logic [7:0]        pkt_data,
    input  logic [7:0]        qual_cfg,
    input  logic [LINE_W-1:0] win_offset,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [3:0]        ir_len,
    input  logic [7:0]        ir_data,
    input  logic              drain_done,
    output logic [3:0]        ir_idx,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [7:0]        buf_wdata,
    output logic              field_ready,
    output logic [PTR_W-1:0]  fill_level,
    output logic              overflow
);
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              line_start, field_start, region_end;
    logic              win_ok, accept, hdr_win;
    logic [7:0]        hdr_id1;

    vbi_sync_tracker #(
        .PIX_W(PIX_W), .LINE_W(LINE_W), .END_LINE(END_LINE)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .line_start(line_start),
        .field_start(field_start), .region_end(region_end)
    );

    // Position window evaluated now; the writer latches it at the SDID byte.
    assign win_ok = (line_cnt >= win_offset) && (pix_cnt < line_len);

    vbi_line_qualifier #(
        .VBI_FIRST(VBI_FIRST), .VBI_LAST(VBI_LAST)
    ) u_qual (
        .qual_cfg(qual_cfg), .win_ok(hdr_win), .hdr_id1(hdr_id1),
        .hdr_id2(pkt_data), .accept(accept)
    );

    vbi_field_writer #(
        .DEPTH(DEPTH), .BURST_LEN(BURST_LEN), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .field_start(field_start),
        .line_start(line_start), .region_end(region_end), .win_ok(win_ok),
        .accept(accept), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .ir_len(ir_len), .ir_data(ir_data), .drain_done(drain_done),
        .ir_idx(ir_idx), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .field_ready(field_ready),
        .fill_level(fill_level), .overflow(overflow),
        .hdr_id1(hdr_id1), .hdr_win(hdr_win)
    );

endmodule

// File: tb/test_vbi_field_packer.sv
// Scoreboard bench: the field driver pushes expected record bytes into a
// queue; the write monitor builds the buffer image; the closer compares.
module test_vbi_field_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync_n = 1'b1, vsync_n = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [7:0]  pkt_data = 8'h00;
    logic [7:0]  qual_cfg = 8'h00;
    logic [8:0]  win_offset = 9'd0;
    logic [10:0] line_len = 11'd0;
    logic [3:0]  ir_len = 4'd7;
    logic [7:0]  ir_data;
    logic        drain_done = 1'b0;
    logic [3:0]  ir_idx;
    logic        buf_we;
    logic [9:0]  buf_waddr;
    logic [7:0]  buf_wdata;
    logic        field_ready;
    logic [10:0] fill_level;
    logic        overflow;

    int nchk = 0, nerr = 0, cyc = 0, wr_in_ready = 0, wr_total = 0;
    logic [7:0] mem [0:1023];
    logic [7:0] exp_q[$];
    bit         exp_ovf;

    bit       p_on [1:21];
    bit       p_bad [1:21];
    bit       p_baddc [1:21];
    bit       p_strad [1:21];
    int       p_dt [1:21];
    int       p_dc [1:21];
    int       p_l [1:21];
    bit       fid = 1'b0;

    localparam int PKT_DELAY = 25;

    always #10 clk = ~clk;

    assign ir_data = 8'hA0 + {4'h0, ir_idx};

    vbi_field_packer i_vbi_field_packer (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .qual_cfg(qual_cfg),
        .win_offset(win_offset), .line_len(line_len), .ir_len(ir_len),
        .ir_data(ir_data), .drain_done(drain_done), .ir_idx(ir_idx),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .field_ready(field_ready), .fill_level(fill_level), .overflow(overflow)
    );

    // Write monitor: builds the buffer image and counts forbidden writes.
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            mem[buf_waddr] = buf_wdata;
            wr_total++;
            if (field_ready) wr_in_ready++;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [7:0] odd_byte(input logic [6:0] v);
        return {~^v, v};
    endfunction

    function automatic logic [7:0] dat(input int i, input int k);
        return 8'(i * 16 + k + 1);
    endfunction

    function automatic bit is_raw(input int dt);
        return dt == 7 || dt == 11 || dt == 15;
    endfunction

    // Expected acceptance per requirements R2..R6 and R11.
    function automatic bit line_ok(input int i);
        logic [8:0] l;
        if (p_bad[i] || p_baddc[i] || p_strad[i]) return 0;
        l = 9'(p_l[i]);
        if (qual_cfg[6] && !((i >= int'(win_offset)) && (PKT_DELAY < int'(line_len)))) return 0;
        if (qual_cfg[4] && !(l >= 2 && l <= 21)) return 0;
        if (qual_cfg[7] && (4'(p_dt[i]) != qual_cfg[3:0])) return 0;
        if (!qual_cfg[5] && is_raw(p_dt[i])) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] id1_of(input int i);
        logic [8:0] l = 9'(p_l[i]);
        return odd_byte({fid, l[8:3]});
    endfunction

    function automatic logic [7:0] id2_of(input int i);
        logic [8:0] l = 9'(p_l[i]);
        logic [7:0] b = odd_byte({l[2:0], 4'(p_dt[i])});
        if (p_bad[i]) b[7] = ~b[7];
        return b;
    endfunction

    // Driver side of the scoreboard: expected record bytes.
    task automatic build_exp();
        int total = 0;
        exp_q.delete();
        exp_ovf = 0;
        for (int i = 1; i <= 21; i++) begin
            if (p_on[i] && line_ok(i)) begin
                if (total + 4 + p_dc[i] > 1024) begin
                    exp_ovf = 1;
                    break;
                end
                exp_q.push_back(8'h85);
                exp_q.push_back({2'b10, 6'(p_dc[i])});
                exp_q.push_back(id1_of(i));
                exp_q.push_back(id2_of(i));
                for (int k = 0; k < p_dc[i]; k++) exp_q.push_back(dat(i, k));
                total += 4 + p_dc[i];
            end
        end
        if (!exp_ovf) begin
            for (int k = 0; k < 16; k++) exp_q.push_back(8'h00);
            exp_q.push_back({4'b0111, ir_len});
            for (int k = 0; k < int'(ir_len); k++) exp_q.push_back(8'hA0 + 8'(k));
        end
    endtask

    task automatic clear_plan();
        for (int i = 1; i <= 21; i++) begin
            p_on[i] = 0; p_bad[i] = 0; p_baddc[i] = 0; p_strad[i] = 0;
            p_dt[i] = 0; p_dc[i] = 0; p_l[i] = i;
        end
    endtask

    task automatic add_line(input int i, input int dt, input int dc);
        p_on[i] = 1; p_dt[i] = dt; p_dc[i] = dc;
    endtask

    task automatic hs_pulse();
        hsync_n = 1'b0;
        repeat (4) tick();
        hsync_n = 1'b1;
        tick();
    endtask

    task automatic send(input logic [7:0] b);
        pkt_valid = 1'b1; pkt_data = b;
        tick();
        pkt_valid = 1'b0;
    endtask

    task automatic send_pkt(input int i, output int used);
        send(8'h85);
        send(p_baddc[i] ? {2'b00, 6'(p_dc[i])} : {2'b10, 6'(p_dc[i])});
        send(id1_of(i));
        send(id2_of(i));
        for (int k = 0; k < p_dc[i]; k++) send(dat(i, k));
        used = 4 + p_dc[i];
    endtask

    // Drives one field: VSYNC, lines 1..21 with their packets, line 22 edge.
    task automatic run_field();
        bit strad = 0;
        int used;
        for (int m = 0; m < 1024; m++) mem[m] = 8'hEE;
        vsync_n = 1'b0;
        repeat (3) tick();
        vsync_n = 1'b1;
        repeat (8) tick();
        for (int i = 1; i <= 21; i++) begin
            hs_pulse();
            repeat (PKT_DELAY) tick();
            used = 0;
            if (p_on[i] && p_strad[i]) begin
                strad = 1;
                send(8'h85); send({2'b10, 6'd63}); send(id1_of(i)); send(id2_of(i));
                send(dat(i, 0)); send(dat(i, 1));
                hs_pulse();
                for (int k = 2; k < 22; k++) send(dat(i, k));
            end else if (p_on[i]) begin
                send_pkt(i, used);
            end
            if (!strad) repeat (70 - used) tick();
        end
        if (!strad) hs_pulse();
        fid = ~fid;
    endtask

    // Closer side of the scoreboard: wait for handover and compare.
    task automatic close_field(input string tag, input bit drain);
        int n = 0;
        while (!field_ready && n < 600) begin tick(); n++; end
        chk({tag, " R9 field_ready"}, 32'(field_ready), 32'd1);
        chk({tag, " R9 fill_level"}, 32'(fill_level), 32'(exp_q.size()));
        chk({tag, " R10 overflow"}, 32'(overflow), 32'(exp_ovf));
        for (int k = 0; k < exp_q.size(); k++)
            chk($sformatf("%s byte %0d", tag, k), 32'(mem[k]), 32'(exp_q[k]));
        if (drain) begin
            drain_done = 1'b1; tick(); drain_done = 1'b0; tick();
            chk({tag, " R9 ready cleared by drain"}, 32'(field_ready), 32'd0);
        end
    endtask

    initial begin
        int wr_before;
        repeat (4) tick();
        // R1 reset state
        chk("R1 field_ready", 32'(field_ready), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
        chk("R1 buf_we", 32'(buf_we), 32'd0);
        chk("R1 fill_level", 32'(fill_level), 32'd0);
        rst_n = 1'b1;
        repeat (4) tick();
        chk("R1 idle no write", 32'(wr_total), 32'd0);

        // R2 R6 R7 R8: header format, bad parity/DC and raw drop, rewind
        clear_plan(); qual_cfg = 8'h00; ir_len = 4'd7;
        add_line(3, 5, 2); add_line(5, 0, 4);
        add_line(7, 1, 2); p_bad[7] = 1;
        add_line(8, 7, 3);
        add_line(9, 3, 0);
        add_line(10, 2, 3); p_baddc[10] = 1;
        add_line(12, 4, 1);
        build_exp(); run_field(); close_field("R2/R6/R7/R8", 1);

        // R6 raw enabled keeps codes 11 and 15; 11 IR bytes
        clear_plan(); qual_cfg = 8'h20; ir_len = 4'd11;
        add_line(4, 11, 5); add_line(6, 15, 1);
        build_exp(); run_field(); close_field("R6/R8 raw on", 1);

        // R5 type filter on code 4
        clear_plan(); qual_cfg = 8'h84; ir_len = 4'd7;
        add_line(2, 4, 3); add_line(3, 5, 2); add_line(4, 4, 0);
        build_exp(); run_field(); close_field("R5 type", 1);

        // R4 header line number window
        clear_plan(); qual_cfg = 8'h10;
        add_line(2, 1, 2); p_l[2] = 1;
        add_line(3, 1, 2); p_l[3] = 2;
        add_line(4, 1, 2); p_l[4] = 21;
        add_line(5, 1, 2); p_l[5] = 22;
        build_exp(); run_field(); close_field("R4 line number", 1);

        // R3 position window by line offset
        clear_plan(); qual_cfg = 8'h40; win_offset = 9'd6; line_len = 11'd600;
        add_line(4, 0, 2); add_line(6, 0, 2); add_line(10, 0, 3);
        build_exp(); run_field(); close_field("R3 offset", 1);

        // R4 both windows intersect
        clear_plan(); qual_cfg = 8'h50; win_offset = 9'd10;
        add_line(5, 0, 2); add_line(12, 0, 2);
        add_line(15, 0, 2); p_l[15] = 25;
        build_exp(); run_field(); close_field("R4 intersect", 1);

        // R3 pixel limit rejects everything
        clear_plan(); qual_cfg = 8'h40; win_offset = 9'd0; line_len = 11'd10;
        add_line(3, 0, 2); add_line(4, 1, 1);
        build_exp(); run_field(); close_field("R3 pixel", 1);

        // R11 packet across the region end is discarded
        clear_plan(); qual_cfg = 8'h00;
        add_line(5, 0, 2); add_line(21, 0, 63); p_strad[21] = 1;
        build_exp(); run_field(); close_field("R11 straddle", 1);

        // R10 overflow: 16 lines of 67 bytes, kept until read out
        clear_plan();
        for (int i = 1; i <= 16; i++) add_line(i, 0, 63);
        build_exp();
        chk("R10 model expects overflow", 32'(exp_ovf), 32'd1);
        run_field(); close_field("R10 overflow", 0);

        // R9 a whole field while ready is ignored
        wr_before = wr_total;
        clear_plan(); add_line(3, 0, 2);
        run_field();
        chk("R9 no writes while ready", 32'(wr_total - wr_before), 32'd0);
        chk("R9 ready held", 32'(field_ready), 32'd1);
        chk("R9 fill held", 32'(fill_level), 32'd1005);
        chk("R10 overflow held", 32'(overflow), 32'd1);
        chk("R9 monitor writes in ready", 32'(wr_in_ready), 32'd0);
        drain_done = 1'b1; tick(); drain_done = 1'b0; tick();

        // R10 next field clears overflow and records normally
        clear_plan(); add_line(4, 2, 1);
        build_exp(); run_field(); close_field("R10 recovery", 1);

        summary();
    end

endmodule